// File: doc/BRIEF.md
# Four-Queue Multiplexing Read Buffer

This block holds four independent first-in first-out queues, each filled from its own write port, and drains all of them through one shared read port. A select input picks, at every clock edge, which queue the read port serves, so traffic that arrives on several paths can be drained onto a single bus. Switching between queues costs no cycles: the select seen at an edge is the one that edge acts on.

Two read-timing modes are offered, and the mode is fixed while reset is held. In fall-through mode the read bus always shows the oldest word of the selected queue. A read request consumes that word and the next one appears. In standard mode the bus changes only when an explicit read takes a word out of the selected queue. A four-bit flag vector reports which queues hold data. Everything runs on one clock.

Top module: `quad_mux_fifo`

## Requirements
- R1: A word on a queue's data input is stored in that queue at a rising edge only when that queue's write enable and write chip select are both low. Otherwise the queue is left unchanged.
- R2: The queue-select input is acted on at the same edge it is sampled. A read at edge k takes its word from the queue named by the select at edge k, and the select may change at every edge.
- R3: A read takes place only when the read enable and the read chip select are both low at the edge. If either is high, no word is consumed.
- R4: In fall-through mode (mode input 1 during reset), a word written into an empty queue that is currently selected appears on the read bus right after its write edge, with no read request. Further words written behind it do not change the bus.
- R5: In fall-through mode, selecting a queue that holds data puts its oldest word on the read bus at that edge, whatever the read enable and read chip select are. A read consumes the shown word, and the next word of the selected queue then appears.
- R6: In standard mode (mode input 0 during reset), the bus changes only on a read. It then shows the oldest word of the selected queue and removes that word. Changing the select without a read keeps the last word on the bus.
- R7: The mode input is captured only while reset is low. Changing it afterwards has no effect.
- R8: Each queue holds DEPTH words (16 by default). A write to a full queue is dropped, and the stored words keep their order.
- R9: In standard mode, a read from an empty queue leaves the read bus unchanged.
- R10: Bit i of the ready vector is 1 exactly when queue i holds at least one word that has not yet been consumed by a read.
- R11: Reset empties all queues, clears the read bus to zero and clears every ready bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all ports |
| rst_n | input | 1 | Active-low reset; the mode is captured while it is low |
| mode_i | input | 1 | Read-timing mode: 1 fall-through, 0 standard |
| wr_en_n | input | NQ | Per-queue write enable, active low |
| wr_cs_n | input | NQ | Per-queue write chip select, active low |
| wr_data | input | NQ*DW | Per-queue write data; queue i uses bits [i*DW +: DW] |
| rd_en_n | input | 1 | Read enable, active low |
| rd_cs_n | input | 1 | Read chip select, active low |
| out_sel | input | SW | Number of the queue served by the read port |
| rd_data | output | DW | Shared read data bus |
| q_ready | output | NQ | Per-queue data-available flags |

## Verification
On every cycle the assertions check these local rules: a full queue does not grow, an empty queue does not shrink, a queue with no write request does not gain a word, standard mode holds the bus when no read or an empty read takes place, the captured mode stays fixed after reset, and reset leaves clean flags and bus. The ordering of words across queues, the zero-cycle select switch, and the fall-through of first words and of switched-to heads can only be shown by the bench scenarios. There, a behavioural queue model follows every cycle of directed and random traffic in both modes.

// File: rtl/qmf_pkg.sv
package qmf_pkg;

  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } rd_mode_e;

  // circular pointer advance for any depth
  function automatic int unsigned wrap_inc(input int unsigned p, input int unsigned lim);
    return (p + 1 == lim) ? 0 : p + 1;
  endfunction

  // occupancy after one edge
  function automatic int unsigned occ_next(input int unsigned c, input bit push, input bit pop);
    return c + (push ? 1 : 0) - (pop ? 1 : 0);
  endfunction

endpackage

// File: rtl/qmf_queue.sv
module qmf_queue #(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic          pop_req,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] head,
  output logic [DW-1:0] head_nxt,
  output logic          head_nxt_vld,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] count
);
  import qmf_pkg::*;

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] ONE_CNT  = CW'(1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr, rd_ptr_p1;
  logic [DW-1:0] second;

  // named events for the checks
  logic push_ok, pop_ok;

  assign empty     = (count == '0);
  assign full      = (count == FULL_CNT);
  assign push_ok   = push_req && !full;
  assign pop_ok    = pop_req && !empty;
  assign rd_ptr_p1 = AW'(wrap_inc(int'(rd_ptr), DEPTH));
  assign head      = mem[rd_ptr];
  assign second    = mem[rd_ptr_p1];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= AW'(wrap_inc(int'(wr_ptr), DEPTH));
      if (pop_ok)  rd_ptr <= rd_ptr_p1;
      count <= CW'(occ_next(int'(count), push_ok, pop_ok));
    end
  end

  // oldest word after this edge, used for fall-through presentation
  always_comb begin
    head_nxt_vld = 1'b0;
    head_nxt     = head;
    if (pop_ok) begin
      if (count > ONE_CNT) begin
        head_nxt_vld = 1'b1;
        head_nxt     = second;
      end else if (push_ok) begin
        head_nxt_vld = 1'b1;
        head_nxt     = din;
      end
    end else if (!empty) begin
      head_nxt_vld = 1'b1;
      head_nxt     = head;
    end else if (push_ok) begin
      head_nxt_vld = 1'b1;
      head_nxt     = din;
    end
  end

  // R8
  full_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push_req && !pop_req) |=> (count == FULL_CNT));

  // R9
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop_req && !push_req) |=> (count == '0));

  // R1
  no_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !push_req |=> (count <= $past(count)));

  // R8
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);

endmodule

// File: rtl/qmf_rdport.sv
module qmf_rdport #(
  parameter int NQ   = 4,
  parameter int DW   = 16,
  localparam int SW  = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  qmf_pkg::rd_mode_e mode,
  input  logic              rd_act,
  input  logic [SW-1:0]     sel,
  input  logic [DW-1:0]     head     [NQ],
  input  logic [DW-1:0]     head_nxt [NQ],
  input  logic [NQ-1:0]     nxt_vld,
  input  logic [NQ-1:0]     empty,
  output logic [DW-1:0]     rd_data
);
  import qmf_pkg::*;

  logic sel_ok;
  logic fwft_load, std_load;

  assign sel_ok    = (int'(sel) < NQ);
  assign fwft_load = (mode == MODE_FWFT) && sel_ok && nxt_vld[sel];
  assign std_load  = (mode == MODE_STD) && sel_ok && rd_act && !empty[sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rd_data <= '0;
    else if (fwft_load) rd_data <= head_nxt[sel];
    else if (std_load)  rd_data <= head[sel];
  end

  // R6
  std_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_STD && !rd_act) |=> $stable(rd_data));

  // R9
  std_empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_STD && rd_act && empty[sel]) |=> $stable(rd_data));

endmodule

// File: rtl/quad_mux_fifo.sv
module quad_mux_fifo #(
  parameter int NQ    = 4,
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  localparam int SW   = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_i,
  input  logic [NQ-1:0]    wr_en_n,
  input  logic [NQ-1:0]    wr_cs_n,
  input  logic [NQ*DW-1:0] wr_data,
  input  logic             rd_en_n,
  input  logic             rd_cs_n,
  input  logic [SW-1:0]    out_sel,
  output logic [DW-1:0]    rd_data,
  output logic [NQ-1:0]    q_ready
);
  import qmf_pkg::*;

  localparam int CW = $clog2(DEPTH + 1);

  rd_mode_e      mode_q;
  logic          rd_act;
  logic [NQ-1:0] wr_act, pop_req, empty_v, full_v, nxt_vld_v;
  logic [DW-1:0] head_a [NQ];
  logic [DW-1:0] nxt_a  [NQ];
  logic [CW-1:0] cnt_a  [NQ];

  // mode captured only while reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= rd_mode_e'(mode_i);
  end

  assign rd_act = !rd_en_n && !rd_cs_n;

  for (genvar gi = 0; gi < NQ; gi++) begin : g_q
    assign wr_act[gi]  = !wr_en_n[gi] && !wr_cs_n[gi];
    assign pop_req[gi] = rd_act && (out_sel == SW'(gi));

    qmf_queue #(.DW(DW), .DEPTH(DEPTH)) u_q (
      .clk          (clk),
      .rst_n        (rst_n),
      .push_req     (wr_act[gi]),
      .pop_req      (pop_req[gi]),
      .din          (wr_data[gi*DW +: DW]),
      .head         (head_a[gi]),
      .head_nxt     (nxt_a[gi]),
      .head_nxt_vld (nxt_vld_v[gi]),
      .empty        (empty_v[gi]),
      .full         (full_v[gi]),
      .count        (cnt_a[gi])
    );
  end

  qmf_rdport #(.NQ(NQ), .DW(DW)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode_q),
    .rd_act   (rd_act),
    .sel      (out_sel),
    .head     (head_a),
    .head_nxt (nxt_a),
    .nxt_vld  (nxt_vld_v),
    .empty    (empty_v),
    .rd_data  (rd_data)
  );

  assign q_ready = ~empty_v;

  // R7
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(mode_q));

  // R11
  rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (q_ready == '0 && rd_data == '0));

  // R3
  no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_n || rd_cs_n) |-> (pop_req == '0));

endmodule

// File: tb/sim_quad_mux_fifo.sv
`timescale 1ns/1ps
module sim_quad_mux_fifo;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_i = 1'b0;
  logic [3:0]  wr_en_n = 4'hF;
  logic [3:0]  wr_cs_n = 4'hF;
  logic [63:0] wr_data = '0;
  logic        rd_en_n = 1'b1;
  logic        rd_cs_n = 1'b1;
  logic [1:0]  out_sel = 2'd0;
  logic [15:0] rd_data;
  logic [3:0]  q_ready;

  int errors = 0;
  int checks = 0;

  logic [15:0] mq [4][$];
  logic [15:0] exp_data;
  bit          exp_fwft;

  always #4 clk = ~clk;

  quad_mux_fifo #(.NQ(4), .DW(16), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .wr_en_n(wr_en_n), .wr_cs_n(wr_cs_n),
    .wr_data(wr_data), .rd_en_n(rd_en_n), .rd_cs_n(rd_cs_n), .out_sel(out_sel),
    .rd_data(rd_data), .q_ready(q_ready)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_ready();
    logic [3:0] r;
    for (int i = 0; i < 4; i++) r[i] = (mq[i].size() > 0);
    return r;
  endfunction

  // one clock: drive at negedge, advance the model, compare at next negedge
  task automatic step(input logic [3:0] we_n, input logic [3:0] cs_n, input logic [63:0] d,
                      input logic ren, input logic rcs, input logic [1:0] sel);
    bit wok [4];
    logic [15:0] tmp;
    int s;
    wr_en_n = we_n; wr_cs_n = cs_n; wr_data = d;
    rd_en_n = ren;  rd_cs_n = rcs;  out_sel = sel;
    s = int'(sel);
    for (int i = 0; i < 4; i++) wok[i] = !we_n[i] && !cs_n[i] && (mq[i].size() < DEPTH);
    if (!ren && !rcs && mq[s].size() > 0) begin
      tmp = mq[s].pop_front();
      if (!exp_fwft) exp_data = tmp;
    end
    for (int i = 0; i < 4; i++) if (wok[i]) mq[i].push_back(d[i*16 +: 16]);
    if (exp_fwft && mq[s].size() > 0) exp_data = mq[s][0];
    @(posedge clk);
    @(negedge clk);
    chk(rd_data === exp_data, "R2 model rd_data", 32'(rd_data), 32'(exp_data));
    chk(q_ready === exp_ready(), "R10 model q_ready", 32'(q_ready), 32'(exp_ready()));
  endtask

  task automatic idle(input logic [1:0] sel);
    step(4'hF, 4'hF, 64'h0, 1'b1, 1'b1, sel);
  endtask

  task automatic wr1(input int q, input logic [15:0] v, input logic [1:0] sel);
    logic [63:0] d = '0;
    d[q*16 +: 16] = v;
    step(~(4'b1 << q), ~(4'b1 << q), d, 1'b1, 1'b1, sel);
  endtask

  task automatic rd1(input logic [1:0] sel);
    step(4'hF, 4'hF, 64'h0, 1'b0, 1'b0, sel);
  endtask

  task automatic do_reset(input bit m);
    @(negedge clk);
    rst_n = 1'b0; mode_i = m;
    wr_en_n = 4'hF; wr_cs_n = 4'hF; rd_en_n = 1'b1; rd_cs_n = 1'b1; out_sel = 2'd0;
    for (int i = 0; i < 4; i++) mq[i].delete();
    exp_data = '0; exp_fwft = m;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(rd_data == 16'h0, "R11 reset rd_data", 32'(rd_data), 32'h0);
    chk(q_ready == 4'h0, "R11 reset q_ready", 32'(q_ready), 32'h0);
  endtask

  task automatic random_run(input int n);
    for (int k = 0; k < n; k++) begin
      logic [63:0] d;
      d = {$urandom(), $urandom()};
      step(4'($urandom()), 4'($urandom_range(0, 3) == 0 ? 4'hF : 4'h0 | 4'($urandom() & 32'h3)),
           d, 1'($urandom_range(0, 2) == 0), 1'($urandom_range(0, 3) == 0), 2'($urandom()));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog timeout");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // ---------------- standard mode ----------------
    do_reset(1'b0);
    // R1: write enable low but chip select high stores nothing
    step(4'b1110, 4'b1111, 64'h00A1, 1'b1, 1'b1, 2'd0);
    chk(q_ready == 4'h0, "R1 cs high blocks write", 32'(q_ready), 32'h0);
    step(4'b1100, 4'b1100, 64'h0000_0000_0B01_00A1, 1'b1, 1'b1, 2'd0);
    wr1(0, 16'h00A2, 2'd0);
    chk(rd_data == 16'h0, "R6 no fall-through in standard", 32'(rd_data), 32'h0);
    chk(q_ready == 4'b0011, "R10 ready after writes", 32'(q_ready), 32'h3);
    // R3: only one of the two read strobes low
    step(4'hF, 4'hF, 64'h0, 1'b0, 1'b1, 2'd0);
    chk(rd_data == 16'h0, "R3 chip select high blocks read", 32'(rd_data), 32'h0);
    rd1(2'd0);
    chk(rd_data == 16'h00A1, "R6 read oldest word", 32'(rd_data), 32'h00A1);
    idle(2'd1);
    chk(rd_data == 16'h00A1, "R6 hold on switch", 32'(rd_data), 32'h00A1);
    rd1(2'd1);
    chk(rd_data == 16'h0B01, "R2 zero-latency switch read", 32'(rd_data), 32'h0B01);
    rd1(2'd2);
    chk(rd_data == 16'h0B01, "R9 empty read keeps bus", 32'(rd_data), 32'h0B01);
    // R7: mode change after reset is ignored
    mode_i = 1'b1;
    wr1(2, 16'h0C01, 2'd2);
    idle(2'd2);
    chk(rd_data == 16'h0B01, "R7 still standard mode", 32'(rd_data), 32'h0B01);
    // R8: seventeen writes, last one dropped
    for (int k = 0; k < 17; k++) wr1(3, 16'h3000 + 16'(k), 2'd0);
    for (int k = 0; k < 15; k++) rd1(2'd3);
    chk(q_ready[3] == 1'b1, "R8 one word left", 32'(q_ready[3]), 32'h1);
    rd1(2'd3);
    chk(rd_data == 16'h300F, "R8 last stored word", 32'(rd_data), 32'h300F);
    chk(q_ready[3] == 1'b0, "R8 overflow word dropped", 32'(q_ready[3]), 32'h0);
    random_run(400);

    // ---------------- fall-through mode ----------------
    do_reset(1'b1);
    wr1(1, 16'h1111, 2'd1);
    chk(rd_data == 16'h1111, "R4 first word falls through", 32'(rd_data), 32'h1111);
    wr1(1, 16'h1112, 2'd1);
    chk(rd_data == 16'h1111, "R4 later word does not fall", 32'(rd_data), 32'h1111);
    wr1(2, 16'h2221, 2'd1);
    idle(2'd2);
    chk(rd_data == 16'h2221, "R5 switch shows new head", 32'(rd_data), 32'h2221);
    rd1(2'd1);
    chk(rd_data == 16'h1112, "R5 read pops and advances", 32'(rd_data), 32'h1112);
    mode_i = 1'b0;
    idle(2'd2);
    chk(rd_data == 16'h2221, "R7 still fall-through mode", 32'(rd_data), 32'h2221);
    random_run(400);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule